// File: doc/BRIEF.md
# DDR3 DLL Read Scheduling Gate

This controller-side block follows the state of the DRAM's delay-locked loop and decides, cycle by cycle, whether a read or a synchronous on-die-termination command may go to the device. It watches mode-register writes, DLL reset commands and self-refresh entry and exit. From these it knows whether the DLL is on, off, or relocking. While the DLL relocks after a reset, reads and ODT are held back for a fixed number of cycles. Writes stay allowed, because they do not need a locked DLL.

The block also gives the read latency that the capture path uses. That is additive latency plus CAS latency with the DLL on, and one cycle less with the DLL off. For each accepted read it raises a marker for the four clock cycles of an eight-beat burst, starting once that latency has elapsed. A request that arrives while it is blocked is refused with a one-cycle reject pulse and is not queued. A sticky error flag reports a clock-enable drop during relock, or latency settings that DLL-off mode does not support.

Top module: `dll_read_gate`

## Requirements
- R1: After reset, the DLL is taken as enabled but not locked: `rd_ok`=0, `odt_ok`=0, `wr_ok`=1, `proto_err`=0, `rd_window`=0.
- R2: A DLL reset command in DLL-on mode, sampled at rising edge k, holds `rd_ok` and `odt_ok` low after edges k through k+TDLLK-1. Both go high after edge k+TDLLK. A further DLL reset during the countdown restarts the full count.
- R3: A read (ODT) request sampled while `rd_ok` (`odt_ok`) is low gives `rd_reject` (`odt_reject`) high for exactly the next cycle, and the request starts no data window. An accepted request gives no reject.
- R4: `wr_ok` stays high during the relock countdown and in DLL-off mode. It is low only in self-refresh.
- R5: `rd_lat` equals AL+CL with the DLL on and AL+CL-1 with the DLL off. For example, CL=6 with AL=0 gives 5 when off.
- R6: A read accepted at edge k with latency L drives `rd_window` high after edges k+L to k+L+3 (four cycles), and low before and after. Reads four cycles apart give one unbroken window.
- R7: An MR1 write (`mrs_sel`=1) with `mrs_a0`=1 enters DLL-off mode: `rd_ok`=1, `odt_ok`=0. An MR1 write with `mrs_a0`=0 returns to DLL-on mode unlocked, so reads and ODT wait for a DLL reset and its countdown.
- R8: Self-refresh entry drops `rd_ok`, `odt_ok` and `wr_ok` on the next cycle. Exit from DLL-on mode restores `wr_ok` and starts the TDLLK countdown exactly as a DLL reset does.
- R9: `cke` low at any edge while the countdown runs sets `proto_err`, and `proto_err` then stays high until reset.
- R10: In DLL-off mode, a CL other than 6 or a CWL other than 6 sets `proto_err` one cycle after the mode takes effect. CL=6 with CWL=6 raises no error.
- R11: Mode-register writes to MR0 (`mrs_sel`=0) or MR2 (`mrs_sel`=2) do not change the DLL mode, whatever `mrs_a0` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_mrs | input | 1 | Mode-register write issued this cycle |
| mrs_sel | input | 2 | Target register of the write: 0 MR0, 1 MR1, 2 MR2, 3 MR3 |
| mrs_a0 | input | 1 | Address bit 0 of the write (DLL disable in MR1) |
| cmd_dll_rst | input | 1 | DLL reset command |
| cmd_sre | input | 1 | Self-refresh entry |
| cmd_srx | input | 1 | Self-refresh exit |
| cmd_rd | input | 1 | Read request |
| cmd_odt | input | 1 | Synchronous ODT request |
| cke | input | 1 | Clock enable level as driven to the device |
| al | input | LAT_W | Programmed additive latency |
| cl | input | LAT_W | Programmed CAS latency |
| cwl | input | LAT_W | Programmed CAS write latency |
| rd_ok | output | 1 | Read may be issued |
| odt_ok | output | 1 | Synchronous ODT may be issued |
| wr_ok | output | 1 | Write may be issued |
| rd_lat | output | LAT_W+1 | Effective read latency in cycles |
| rd_window | output | 1 | Read data valid window for a BL8 burst |
| rd_reject | output | 1 | One-cycle pulse: read refused |
| odt_reject | output | 1 | One-cycle pulse: ODT refused |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The permit flags change one cycle after the edge that samples a command. The reject pulses are due in the cycle after the request edge. `proto_err` rises one cycle after the offending sample. `rd_lat` follows the settings in the same cycle, and `rd_window` rises exactly L cycles after the edge that accepted the read. The bench drives every input at the falling edge. It counts rising edges from the edge that sampled a stimulus and reads each output at the falling edge of the cycle in which that result is due. For the countdown and the window, it also checks every cycle before and after, so a result one cycle early or late is reported.

// File: rtl/dll_gate_pkg.sv
package dll_gate_pkg;

    // Mode-register selector as carried on mrs_sel
    typedef enum logic [1:0] {
        MRSEL_MR0 = 2'd0,
        MRSEL_MR1 = 2'd1,
        MRSEL_MR2 = 2'd2,
        MRSEL_MR3 = 2'd3
    } mr_sel_e;

    // Beats per read burst and data-rate factor
    localparam int unsigned BURST_BEATS = 8;
    localparam int unsigned BEATS_PER_CLK = 2;

    // Reject pulse pair registered at the top
    typedef struct packed {
        logic rd_rej;
        logic odt_rej;
    } reject_t;

endpackage

// File: rtl/dll_mode_tracker.sv
module dll_mode_tracker
    import dll_gate_pkg::*;
#(
    parameter int unsigned TDLLK   = 512,
    parameter int unsigned LAT_W   = 5,
    parameter int unsigned OFF_CL  = 6,
    parameter int unsigned OFF_CWL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_mrs,
    input  logic [1:0]       mrs_sel,
    input  logic             mrs_a0,
    input  logic             cmd_dll_rst,
    input  logic             cmd_sre,
    input  logic             cmd_srx,
    input  logic             cke,
    input  logic [LAT_W-1:0] cl,
    input  logic [LAT_W-1:0] cwl,
    output logic             dll_off,
    output logic             in_sr,
    output logic             locked,
    output logic             relock_busy,
    output logic             proto_err
);

    localparam int unsigned CNT_W = $clog2(TDLLK + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TDLLK);
    localparam logic [LAT_W-1:0] CL_OFF_V = LAT_W'(OFF_CL);
    localparam logic [LAT_W-1:0] CWL_OFF_V = LAT_W'(OFF_CWL);

    typedef struct packed {
        logic             dll_off;
        logic             in_sr;
        logic             locked;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } trk_t;

    trk_t trk_d, trk_q;

    logic mr1_write;
    logic bad_off_cfg;
    logic cke_drop;

    always_comb begin
        mr1_write   = cmd_mrs && (mr_sel_e'(mrs_sel) == MRSEL_MR1);
        bad_off_cfg = trk_q.dll_off && ((cl != CL_OFF_V) || (cwl != CWL_OFF_V));
        cke_drop    = (trk_q.cnt != '0) && !cke;

        trk_d = trk_q;

        // relock countdown
        if (trk_q.cnt != '0) begin
            trk_d.cnt = trk_q.cnt - 1'b1;
            if (trk_q.cnt == CNT_W'(1)) begin
                trk_d.locked = 1'b1;
            end
        end

        // command effects, highest priority first
        if (cmd_sre && !trk_q.in_sr) begin
            trk_d.in_sr  = 1'b1;
            trk_d.locked = 1'b0;
            trk_d.cnt    = '0;
        end else if (cmd_srx && trk_q.in_sr) begin
            trk_d.in_sr  = 1'b0;
            trk_d.locked = 1'b0;
            trk_d.cnt    = trk_q.dll_off ? '0 : CNT_LOAD;
        end else if (!trk_q.in_sr && mr1_write) begin
            if (mrs_a0 && !trk_q.dll_off) begin
                trk_d.dll_off = 1'b1;
                trk_d.locked  = 1'b0;
                trk_d.cnt     = '0;
            end else if (!mrs_a0 && trk_q.dll_off) begin
                trk_d.dll_off = 1'b0;
                trk_d.locked  = 1'b0;
                trk_d.cnt     = '0;
            end
        end else if (!trk_q.in_sr && !trk_q.dll_off && cmd_dll_rst) begin
            trk_d.locked = 1'b0;
            trk_d.cnt    = CNT_LOAD;
        end

        // sticky protocol error
        if (cke_drop || bad_off_cfg) begin
            trk_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{dll_off: 1'b0, in_sr: 1'b0, locked: 1'b0, cnt: '0, err: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign dll_off     = trk_q.dll_off;
    assign in_sr       = trk_q.in_sr;
    assign locked      = trk_q.locked;
    assign relock_busy = (trk_q.cnt != '0);
    assign proto_err   = trk_q.err;

endmodule

// File: rtl/rl_window_gen.sv
module rl_window_gen
    import dll_gate_pkg::*;
#(
    parameter int unsigned LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic             dll_off,
    input  logic [LAT_W-1:0] al,
    input  logic [LAT_W-1:0] cl,
    output logic [LAT_W:0]   rd_lat,
    output logic             rd_window
);

    localparam int unsigned RL_W   = LAT_W + 1;
    localparam int unsigned DEPTH  = 1 << RL_W;
    localparam int unsigned BEATS  = BURST_BEATS / BEATS_PER_CLK;
    localparam int unsigned BCNT_W = $clog2(BEATS + 1);

    typedef struct packed {
        logic [DEPTH-1:0]  starts;
        logic [BCNT_W-1:0] beats;
    } win_t;

    win_t win_d, win_q;

    logic [RL_W-1:0] lat_sum;
    logic [RL_W-1:0] lat_eff;
    logic [RL_W-1:0] lat_sched;

    always_comb begin
        lat_sum   = {1'b0, al} + {1'b0, cl};
        lat_eff   = dll_off ? (lat_sum - 1'b1) : lat_sum;
        lat_sched = (lat_eff == '0) ? RL_W'(1) : lat_eff;

        win_d        = win_q;
        win_d.starts = win_q.starts >> 1;
        if (rd_go) begin
            win_d.starts[lat_sched - 1'b1] = 1'b1;
        end

        if (win_q.starts[0]) begin
            win_d.beats = BCNT_W'(BEATS);
        end else if (win_q.beats != '0) begin
            win_d.beats = win_q.beats - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '{starts: '0, beats: '0};
        end else begin
            win_q <= win_d;
        end
    end

    assign rd_lat    = lat_eff;
    assign rd_window = (win_q.beats != '0);

endmodule

// File: rtl/dll_read_gate.sv
module dll_read_gate
    import dll_gate_pkg::*;
#(
    parameter int unsigned TDLLK   = 512,
    parameter int unsigned LAT_W   = 5,
    parameter int unsigned OFF_CL  = 6,
    parameter int unsigned OFF_CWL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_mrs,
    input  logic [1:0]       mrs_sel,
    input  logic             mrs_a0,
    input  logic             cmd_dll_rst,
    input  logic             cmd_sre,
    input  logic             cmd_srx,
    input  logic             cmd_rd,
    input  logic             cmd_odt,
    input  logic             cke,
    input  logic [LAT_W-1:0] al,
    input  logic [LAT_W-1:0] cl,
    input  logic [LAT_W-1:0] cwl,
    output logic             rd_ok,
    output logic             odt_ok,
    output logic             wr_ok,
    output logic [LAT_W:0]   rd_lat,
    output logic             rd_window,
    output logic             rd_reject,
    output logic             odt_reject,
    output logic             proto_err
);

    logic dll_off;
    logic in_sr;
    logic locked;
    logic relock_busy;
    logic rd_go;

    reject_t rej_d, rej_q;

    dll_mode_tracker #(
        .TDLLK  (TDLLK),
        .LAT_W  (LAT_W),
        .OFF_CL (OFF_CL),
        .OFF_CWL(OFF_CWL)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_mrs    (cmd_mrs),
        .mrs_sel    (mrs_sel),
        .mrs_a0     (mrs_a0),
        .cmd_dll_rst(cmd_dll_rst),
        .cmd_sre    (cmd_sre),
        .cmd_srx    (cmd_srx),
        .cke        (cke),
        .cl         (cl),
        .cwl        (cwl),
        .dll_off    (dll_off),
        .in_sr      (in_sr),
        .locked     (locked),
        .relock_busy(relock_busy),
        .proto_err  (proto_err)
    );

    // Permits: reads need a locked DLL or DLL-off mode, ODT needs lock
    always_comb begin
        rd_ok  = !in_sr && (dll_off || locked);
        odt_ok = !in_sr && !dll_off && locked;
        wr_ok  = !in_sr;
        rd_go  = cmd_rd && rd_ok;

        rej_d.rd_rej  = cmd_rd && !rd_ok;
        rej_d.odt_rej = cmd_odt && !odt_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_q <= '{rd_rej: 1'b0, odt_rej: 1'b0};
        end else begin
            rej_q <= rej_d;
        end
    end

    assign rd_reject  = rej_q.rd_rej;
    assign odt_reject = rej_q.odt_rej;

    rl_window_gen #(
        .LAT_W(LAT_W)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .dll_off  (dll_off),
        .al       (al),
        .cl       (cl),
        .rd_lat   (rd_lat),
        .rd_window(rd_window)
    );

endmodule

// File: rtl/dll_read_gate_sva.sv
module dll_read_gate_sva #(
    parameter int unsigned LAT_W   = 5,
    parameter int unsigned OFF_CL  = 6,
    parameter int unsigned OFF_CWL = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_mrs,
    input logic [1:0]       mrs_sel,
    input logic             mrs_a0,
    input logic             cmd_dll_rst,
    input logic             cmd_sre,
    input logic             cmd_rd,
    input logic             cmd_odt,
    input logic             cke,
    input logic [LAT_W-1:0] al,
    input logic [LAT_W-1:0] cl,
    input logic [LAT_W-1:0] cwl,
    input logic             rd_ok,
    input logic             odt_ok,
    input logic             wr_ok,
    input logic [LAT_W:0]   rd_lat,
    input logic             rd_reject,
    input logic             odt_reject,
    input logic             proto_err,
    input logic             dll_off,
    input logic             relock_busy
);

    // R2: a DLL reset in DLL-on mode blocks reads and ODT on the next cycle
    assert_relock_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dll_rst && wr_ok && !dll_off) |=> (!rd_ok && !odt_ok));

    // R3: refused requests pulse the reject, accepted ones do not
    assert_rd_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !rd_ok) |=> rd_reject);
    assert_odt_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_odt && !odt_ok) |=> odt_reject);
    assert_no_false_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rd || rd_ok) |=> !rd_reject);

    // R4: writes stay allowed during relock
    assert_wr_in_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        relock_busy |-> wr_ok);

    // R5: entering DLL-off shortens the latency by one cycle
    assert_off_lat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dll_off) && $stable(al) && $stable(cl)) |-> (rd_lat == $past(rd_lat) - 1'b1));

    // R7: MR1 with A0 set removes ODT permission
    assert_mr1_off_odt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrs && mrs_sel == 2'd1 && mrs_a0 && wr_ok) |=> !odt_ok);

    // R8: self-refresh entry closes every permit
    assert_sre_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sre |=> (!wr_ok && !rd_ok && !odt_ok));

    // R9: clock-enable drop during relock raises a sticky error
    assert_cke_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_busy && !cke) |=> proto_err);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R10: unsupported latency settings in DLL-off mode raise the error
    assert_off_cfg_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_off && (cl != LAT_W'(OFF_CL) || cwl != LAT_W'(OFF_CWL))) |=> proto_err);

endmodule

bind dll_read_gate dll_read_gate_sva #(
    .LAT_W  (LAT_W),
    .OFF_CL (OFF_CL),
    .OFF_CWL(OFF_CWL)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_mrs    (cmd_mrs),
    .mrs_sel    (mrs_sel),
    .mrs_a0     (mrs_a0),
    .cmd_dll_rst(cmd_dll_rst),
    .cmd_sre    (cmd_sre),
    .cmd_rd     (cmd_rd),
    .cmd_odt    (cmd_odt),
    .cke        (cke),
    .al         (al),
    .cl         (cl),
    .cwl        (cwl),
    .rd_ok      (rd_ok),
    .odt_ok     (odt_ok),
    .wr_ok      (wr_ok),
    .rd_lat     (rd_lat),
    .rd_reject  (rd_reject),
    .odt_reject (odt_reject),
    .proto_err  (proto_err),
    .dll_off    (dll_off),
    .relock_busy(relock_busy)
);

// File: tb/dll_read_gate_bench.sv
module dll_read_gate_bench;

    localparam int TDLLK = 512;
    localparam int LAT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_mrs = 1'b0;
    logic [1:0]       mrs_sel = 2'd0;
    logic             mrs_a0 = 1'b0;
    logic             cmd_dll_rst = 1'b0;
    logic             cmd_sre = 1'b0;
    logic             cmd_srx = 1'b0;
    logic             cmd_rd = 1'b0;
    logic             cmd_odt = 1'b0;
    logic             cke = 1'b1;
    logic [LAT_W-1:0] al = '0;
    logic [LAT_W-1:0] cl = 5'd6;
    logic [LAT_W-1:0] cwl = 5'd6;
    logic             rd_ok, odt_ok, wr_ok, rd_window, rd_reject, odt_reject, proto_err;
    logic [LAT_W:0]   rd_lat;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dll_read_gate u_dll_read_gate (
        .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .mrs_sel(mrs_sel), .mrs_a0(mrs_a0),
        .cmd_dll_rst(cmd_dll_rst), .cmd_sre(cmd_sre), .cmd_srx(cmd_srx), .cmd_rd(cmd_rd),
        .cmd_odt(cmd_odt), .cke(cke), .al(al), .cl(cl), .cwl(cwl), .rd_ok(rd_ok),
        .odt_ok(odt_ok), .wr_ok(wr_ok), .rd_lat(rd_lat), .rd_window(rd_window),
        .rd_reject(rd_reject), .odt_reject(odt_reject), .proto_err(proto_err)
    );

    function automatic int exp_lat(input int a, input int c, input bit off);
        return off ? (a + c - 1) : (a + c);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_mrs(input int sel, input bit a0);
        cmd_mrs = 1'b1; mrs_sel = 2'(sel); mrs_a0 = a0;
        step();
        cmd_mrs = 1'b0; mrs_a0 = 1'b0;
    endtask

    task automatic pulse_dll_rst();
        cmd_dll_rst = 1'b1;
        step();
        cmd_dll_rst = 1'b0;
    endtask

    // Call right after the edge that started the countdown
    task automatic expect_relock(input string req);
        int bad = 0;
        if (rd_ok || odt_ok || !wr_ok) bad++;
        repeat (TDLLK - 1) begin
            step();
            if (rd_ok || odt_ok || !wr_ok) bad++;
        end
        chk({req, " blocked cycles"}, bad, 0);
        step();
        chk({req, " unlocked after count"}, int'(rd_ok && odt_ok), 1);
    endtask

    // Issue one read; window must sit at cycles L..L+3 after the edge
    task automatic read_window(input string req, input int lat);
        int miss = 0;
        cmd_rd = 1'b1;
        step();
        cmd_rd = 1'b0;
        if (rd_window || rd_reject) miss++;
        for (int j = 1; j <= lat + 5; j++) begin
            step();
            if (rd_window != ((j >= lat) && (j <= lat + 3))) miss++;
        end
        chk(req, miss, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1 rd_ok", int'(rd_ok), 0);
        chk("R1 odt_ok", int'(odt_ok), 0);
        chk("R1 wr_ok", int'(wr_ok), 1);
        chk("R1 proto_err", int'(proto_err), 0);
        chk("R1 rd_window", int'(rd_window), 0);

        // R3: requests while blocked are refused for one cycle, no window
        cmd_rd = 1'b1; cmd_odt = 1'b1;
        step();
        cmd_rd = 1'b0; cmd_odt = 1'b0;
        chk("R3 rd_reject pulse", int'(rd_reject), 1);
        chk("R3 odt_reject pulse", int'(odt_reject), 1);
        begin
            int seen = 0;
            step();
            if (rd_reject || odt_reject) seen++;
            repeat (12) begin
                step();
                if (rd_window) seen++;
            end
            chk("R3 single pulse and no window", seen, 0);
        end

        // R2 and R4: countdown after DLL reset, then a reload mid-count
        pulse_dll_rst();
        repeat (50) step();
        chk("R2 still blocked mid-count", int'(rd_ok), 0);
        pulse_dll_rst();
        expect_relock("R2 R4 reload");

        // R3: accepted read gives no reject
        cmd_rd = 1'b1;
        step();
        cmd_rd = 1'b0;
        chk("R3 accepted read no reject", int'(rd_reject), 0);
        repeat (20) step();

        // R5 and R6: random settings with the DLL on
        for (int n = 0; n < 40; n++) begin
            int c = 5 + int'($urandom % 10);
            int sel = int'($urandom % 3);
            int a = (sel == 0) ? 0 : (c - sel);
            al = LAT_W'(a); cl = LAT_W'(c); cwl = LAT_W'(5 + ($urandom % 6));
            #1;
            chk("R5 on latency", int'(rd_lat), exp_lat(a, c, 1'b0));
            read_window("R6 window placement", exp_lat(a, c, 1'b0));
        end

        // R6: reads four cycles apart merge into one window
        al = '0; cl = 5'd6; cwl = 5'd6;
        begin
            int miss = 0;
            cmd_rd = 1'b1; step(); cmd_rd = 1'b0;
            repeat (3) step();
            cmd_rd = 1'b1; step(); cmd_rd = 1'b0;
            for (int j = 5; j <= 15; j++) begin
                step();
                if (rd_window != ((j >= 6) && (j <= 13))) miss++;
            end
            chk("R6 back-to-back window", miss, 0);
        end

        // R11: MR0 and MR2 writes leave the DLL mode alone
        pulse_mrs(0, 1'b1);
        pulse_mrs(2, 1'b1);
        chk("R11 odt_ok kept", int'(odt_ok), 1);
        chk("R11 latency kept", int'(rd_lat), 6);

        // R7, R5, R4: enter DLL-off mode
        pulse_mrs(1, 1'b1);
        chk("R7 off rd_ok", int'(rd_ok), 1);
        chk("R7 off odt_ok", int'(odt_ok), 0);
        chk("R4 off wr_ok", int'(wr_ok), 1);
        chk("R5 off latency", int'(rd_lat), 5);
        read_window("R6 off window", 5);
        cmd_odt = 1'b1; step(); cmd_odt = 1'b0;
        chk("R3 odt refused in off mode", int'(odt_reject), 1);
        repeat (4) step();
        chk("R10 supported off settings no error", int'(proto_err), 0);

        // R7: back to DLL-on, unlocked until a DLL reset
        pulse_mrs(1, 1'b0);
        chk("R7 on again rd_ok", int'(rd_ok), 0);
        chk("R7 on again odt_ok", int'(odt_ok), 0);
        chk("R5 on latency restored", int'(rd_lat), 6);
        pulse_dll_rst();
        expect_relock("R7 relock");

        // R8: self-refresh entry and exit
        cmd_sre = 1'b1; step(); cmd_sre = 1'b0;
        chk("R8 sr wr_ok", int'(wr_ok), 0);
        chk("R8 sr rd_ok", int'(rd_ok), 0);
        chk("R8 sr odt_ok", int'(odt_ok), 0);
        cke = 1'b0;
        repeat (10) step();
        cke = 1'b1;
        cmd_srx = 1'b1; step(); cmd_srx = 1'b0;
        chk("R8 exit wr_ok", int'(wr_ok), 1);
        expect_relock("R8 exit relock");
        chk("R9 no error with cke low outside countdown", int'(proto_err), 0);

        // R9: cke drop during countdown, sticky
        pulse_dll_rst();
        cke = 1'b0; step(); cke = 1'b1;
        chk("R9 cke drop error", int'(proto_err), 1);
        repeat (5) step();
        chk("R9 error sticky", int'(proto_err), 1);

        // R10: unsupported CL in DLL-off mode
        rst_n = 1'b0; repeat (2) step(); rst_n = 1'b1; step();
        chk("R1 error cleared by reset", int'(proto_err), 0);
        cl = 5'd7;
        pulse_mrs(1, 1'b1);
        chk("R10 no error at mode edge", int'(proto_err), 0);
        step();
        chk("R10 bad CL error", int'(proto_err), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule